// File: doc/BRIEF.md
# DMA Byte-Lane Packing Unit

This unit sits between a DMA requester that moves 24-bit words and an external memory bus. When packing is on, one DMA word write becomes three byte writes to consecutive addresses. One DMA word read is built from three byte reads. The byte order is little endian. All byte traffic uses data lines 7:0, and the unit holds a bus-lock output to the arbiter so that the three beats stay one indivisible access. When packing is off, or when the access comes from the core, the word passes through as one 24-bit transfer.

The requester raises `req_valid` with the address, direction, origin and write data, and holds them until `req_ack` pulses. Every bus beat stays presented until the memory answers with `bus_ready`. A read returns its assembled word on `rd_data` together with `rd_done` in the same cycle as the acknowledge. The packing mode is a configuration bit that software loads through `cfg_we`. The unit samples that bit once, when it accepts an access.

Top module: `dma_byte_packer`

## Requirements
- R1: The packing configuration bit is 0 after reset. A DMA access issued before the bit is ever loaded therefore runs as one 24-bit beat with `bus_lock` low, and the bus port is idle out of reset (`bus_strobe`, `bus_lock`, `req_ack` and `rd_done` all 0).
- R2: With packing on (`cfg_pack_in`=1 loaded) and `req_core`=0, an access makes exactly three beats at addresses A, A+1 and A+2, in that order. Address arithmetic wraps modulo 2^ADDR_W.
- R3: In a packed write, beat k (k = 0, 1, 2) drives `req_wdata[8k+7:8k]` on `bus_wdata[7:0]`, with `bus_wdata[23:8]` at zero.
- R4: In a packed read, the byte sampled from `bus_rdata[7:0]` on beat k lands in `rd_data[8k+7:8k]`. Lines `bus_rdata[23:8]` have no effect. `rd_done` pulses with the acknowledge.
- R5: A beat moves on only on a clock edge where `bus_strobe` and `bus_ready` are both high. Until then its address, data and direction hold steady.
- R6: `req_ack` is a single-cycle pulse. It appears in the cycle right after the edge that completes the final beat, and once per access.
- R7: For a packed access, `bus_lock` is high from the first beat until the third beat completes. It is low at all other times.
- R8: With packing off, an access is one beat at address A carrying the full 24-bit word in both directions, and `bus_lock` stays low.
- R9: A core access (`req_core`=1) is always one 24-bit beat, even with packing on.
- R10: The unit samples the packing mode when it accepts an access. Loading a new configuration value during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load strobe for the packing configuration bit |
| cfg_pack_in | input | 1 | New packing bit (1 = pack) |
| req_valid | input | 1 | Access request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | 1 | 1 = core-initiated access (never packed) |
| req_addr | input | ADDR_W | Word address A |
| req_wdata | input | DATA_W | Write word |
| req_ack | output | 1 | One-cycle acknowledge after the final beat |
| rd_data | output | DATA_W | Assembled read word |
| rd_done | output | 1 | Read word valid pulse |
| bus_addr | output | ADDR_W | External beat address |
| bus_wdata | output | DATA_W | External write data |
| bus_rdata | input | DATA_W | External read data |
| bus_we | output | 1 | External write strobe |
| bus_strobe | output | 1 | External beat active |
| bus_ready | input | 1 | External beat completion |
| bus_lock | output | 1 | Hold bus ownership for the packed sequence |

## Verification
The unit accepts an access on the first rising edge where `req_valid` is high. Beat 0 then appears on the bus in the next cycle, and each later beat appears in the cycle after the edge where the previous beat saw `bus_ready`. `req_ack`, `rd_done` and `rd_data` become due in the cycle after the edge where the final beat saw `bus_ready`, and `req_ack` must be low again one cycle later. The bench drives `bus_ready` and read data at the falling edge and samples every output at the falling edge. It uses its own beat counter to predict which address and byte are due in each strobed cycle. It checks the acknowledge and the read word in the falling-edge slot that follows the final ready.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dbp_state_t;

  typedef struct packed {
    logic pack;
    logic write;
  } dbp_mode_t;

endpackage

// File: rtl/dbp_cfg.sv
module dbp_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_pack_in,
  output logic pack_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pack_q <= 1'b0;
    else if (cfg_we) pack_q <= cfg_pack_in;
  end

endmodule

// File: rtl/dbp_seq.sv
module dbp_seq #(
  parameter int BEATS = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             want_pack,
  input  logic             bus_ready,
  output logic             accept,
  output logic             busy,
  output logic             mode_pack,
  output logic             mode_write,
  output logic [IDX_W-1:0] beat_idx,
  output logic             beat_done,
  output logic             last_beat,
  output logic             ack_q
);
  import dbp_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  dbp_state_t state_q;
  dbp_mode_t  mode_q;

  assign busy       = (state_q == ST_RUN);
  assign mode_pack  = mode_q.pack;
  assign mode_write = mode_q.write;
  assign accept     = !busy && req_valid && !ack_q;
  assign beat_done  = busy && bus_ready;
  assign last_beat  = !mode_q.pack || (beat_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= '0;
      beat_idx <= '0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= beat_done && last_beat;
      if (accept) begin
        state_q      <= ST_RUN;
        beat_idx     <= '0;
        mode_q.pack  <= want_pack;
        mode_q.write <= req_write;
      end else if (beat_done) begin
        if (last_beat) state_q  <= ST_IDLE;
        else           beat_idx <= beat_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dbp_lane.sv
module dbp_lane #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 24,
  parameter int BYTE_W = 8,
  parameter int BEATS  = 3,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              busy,
  input  logic              mode_pack,
  input  logic              mode_write,
  input  logic [IDX_W-1:0]  beat_idx,
  input  logic              beat_done,
  input  logic              last_beat,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done
);

  localparam int SLOTS = 2 ** IDX_W;
  localparam int HI_W  = DATA_W - BYTE_W;

  function automatic logic [DATA_W-1:0] put_byte(
    input logic [DATA_W-1:0] word,
    input logic [IDX_W-1:0]  k,
    input logic [BYTE_W-1:0] b
  );
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] ins;
    mask = {{HI_W{1'b0}}, {BYTE_W{1'b1}}} << (int'(k) * BYTE_W);
    ins  = {{HI_W{1'b0}}, b} << (int'(k) * BYTE_W);
    return (word & ~mask) | ins;
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] stg_q;
  logic [DATA_W-1:0] stg_next;
  logic [BYTE_W-1:0] slot [SLOTS];
  logic [BYTE_W-1:0] wr_byte;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < BEATS) begin : g_used
      assign slot[g] = wdata_q[g*BYTE_W +: BYTE_W];
    end else begin : g_spare
      assign slot[g] = '0;
    end
  end

  assign wr_byte  = slot[beat_idx];
  assign stg_next = put_byte(stg_q, beat_idx, bus_rdata[BYTE_W-1:0]);
  assign bus_addr = mode_pack ? addr_q + ADDR_W'(beat_idx) : addr_q;

  always_comb begin
    if (!busy)          bus_wdata = '0;
    else if (mode_pack) bus_wdata = {{HI_W{1'b0}}, wr_byte};
    else                bus_wdata = wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      stg_q   <= '0;
      rd_data <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= beat_done && last_beat && !mode_write;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        stg_q   <= '0;
      end else if (beat_done && !mode_write) begin
        if (mode_pack) stg_q <= stg_next;
        if (last_beat) rd_data <= mode_pack ? stg_next : bus_rdata;
      end
    end
  end

endmodule

// File: rtl/dma_byte_packer.sv
module dma_byte_packer #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_pack_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_core,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_we,
  output logic              bus_strobe,
  input  logic              bus_ready,
  output logic              bus_lock
);

  localparam int BEATS = DATA_W / BYTE_W;
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic             pack_q;
  logic             want_pack;
  logic             accept;
  logic             busy;
  logic             mode_pack;
  logic             mode_write;
  logic [IDX_W-1:0] beat_idx;
  logic             beat_done;
  logic             last_beat;
  logic             ack_q;

  assign want_pack = pack_q && !req_core;

  dbp_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_pack_in (cfg_pack_in),
    .pack_q      (pack_q)
  );

  dbp_seq #(.BEATS(BEATS), .IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .want_pack  (want_pack),
    .bus_ready  (bus_ready),
    .accept     (accept),
    .busy       (busy),
    .mode_pack  (mode_pack),
    .mode_write (mode_write),
    .beat_idx   (beat_idx),
    .beat_done  (beat_done),
    .last_beat  (last_beat),
    .ack_q      (ack_q)
  );

  dbp_lane #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
    .BEATS(BEATS), .IDX_W(IDX_W)
  ) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .busy       (busy),
    .mode_pack  (mode_pack),
    .mode_write (mode_write),
    .beat_idx   (beat_idx),
    .beat_done  (beat_done),
    .last_beat  (last_beat),
    .bus_rdata  (bus_rdata),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rd_data    (rd_data),
    .rd_done    (rd_done)
  );

  assign req_ack    = ack_q;
  assign bus_strobe = busy;
  assign bus_we     = busy && mode_write;
  assign bus_lock   = busy && mode_pack;

endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 24,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pack_q,
  input logic              beat_done,
  input logic              last_beat,
  input logic              req_ack,
  input logic              rd_done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_strobe,
  input logic              bus_ready,
  input logic              bus_lock
);

  p_cfg_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pack_q);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !last_beat) |=> (bus_addr == $past(bus_addr) + 1'b1));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_we && bus_lock) |-> (bus_wdata[DATA_W-1:BYTE_W] == '0));

  p_rd_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> req_ack);

  p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !bus_ready) |=> (bus_strobe && $stable(bus_addr) &&
                                    $stable(bus_wdata) && $stable(bus_we)));

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  p_ack_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> $past(beat_done && last_beat));

  p_lock_in_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |-> bus_strobe);

  p_lock_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_lock && !(beat_done && last_beat)) |=> bus_lock);

endmodule

bind dma_byte_packer dbp_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pack_q     (pack_q),
  .beat_done  (beat_done),
  .last_beat  (last_beat),
  .req_ack    (req_ack),
  .rd_done    (rd_done),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_strobe (bus_strobe),
  .bus_ready  (bus_ready),
  .bus_lock   (bus_lock)
);

// File: tb/sim_dma_byte_packer.sv
module sim_dma_byte_packer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_pack_in = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_core = 1'b0;
  logic [23:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic        req_ack;
  logic [23:0] rd_data;
  logic        rd_done;
  logic [23:0] bus_addr;
  logic [23:0] bus_wdata;
  logic [23:0] bus_rdata = '0;
  logic        bus_we;
  logic        bus_strobe;
  logic        bus_ready = 1'b0;
  logic        bus_lock;

  int n_chk = 0;
  int n_bad = 0;
  bit cfg_m = 1'b0;

  always #5 clk = ~clk;

  dma_byte_packer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pack_in(cfg_pack_in),
    .req_valid(req_valid), .req_write(req_write), .req_core(req_core),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rd_data(rd_data), .rd_done(rd_done), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_we(bus_we),
    .bus_strobe(bus_strobe), .bus_ready(bus_ready), .bus_lock(bus_lock)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h96;
  endfunction

  function automatic logic [23:0] mem_word(input logic [23:0] a);
    return (a * 24'd5) ^ 24'h5A3C71;
  endfunction

  function automatic logic [23:0] packed_word(input logic [23:0] a);
    logic [23:0] a1;
    logic [23:0] a2;
    a1 = a + 24'd1;
    a2 = a + 24'd2;
    return {mem_byte(a2), mem_byte(a1), mem_byte(a)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input bit v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_pack_in = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m = v;
  endtask

  task automatic access(input bit wr, input bit core, input logic [23:0] a,
                        input logic [23:0] d, input int rdy_pct, input bit flip);
    bit pk;
    bit done;
    bit flipped;
    int beats;
    int cyc;
    int nexp;
    logic [23:0] ea;
    logic [23:0] ew;
    logic [31:0] r;
    pk = cfg_m && !core;
    nexp = pk ? 3 : 1;
    done = 0; flipped = 0; beats = 0; cyc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_core = core;
    req_addr = a; req_wdata = d;
    while (!done) begin
      @(negedge clk);
      cfg_we = 1'b0;
      cyc++;
      bus_ready = 1'b0;
      if (req_ack) begin
        done = 1;
        chk(beats == nexp, pk ? "R2 beat count" : "R8/R9 beat count", beats, nexp);
        if (wr) begin
          chk(rd_done == 1'b0, "R6 no rd_done on write", rd_done, 0);
        end else begin
          ew = pk ? packed_word(a) : mem_word(a);
          chk(rd_done == 1'b1, "R4 rd_done", rd_done, 1);
          chk(rd_data == ew, pk ? "R4 packed read" : "R8 word read", rd_data, ew);
        end
        chk(bus_lock == 1'b0, "R7 lock released", bus_lock, 0);
        req_valid = 1'b0;
      end else if (bus_strobe) begin
        if (flip && !flipped) begin
          cfg_we = 1'b1;
          cfg_pack_in = !cfg_m;
          cfg_m = !cfg_m;
          flipped = 1;
        end
        ea = pk ? a + 24'(beats) : a;
        chk(beats < nexp, "R6 beat after final", beats, nexp);
        chk(bus_addr == ea, pk ? "R2/R5 beat address" : "R8/R9 address", bus_addr, ea);
        chk(bus_lock == pk, pk ? "R7 lock held" : "R10/R9 lock low", bus_lock, pk);
        chk(bus_we == wr, "R5 direction", bus_we, wr);
        if (wr) begin
          ew = pk ? {16'h0, d[8*beats +: 8]} : d;
          chk(bus_wdata == ew, pk ? "R3 packed write lane" : "R8 word write", bus_wdata, ew);
        end
        r = $urandom;
        if (int'($urandom_range(99)) < rdy_pct) begin
          bus_ready = 1'b1;
          bus_rdata = pk ? {r[15:0], mem_byte(ea)} : mem_word(a);
          beats++;
        end else begin
          bus_rdata = r[23:0];
        end
      end
      if (cyc > 80) begin
        chk(0, "R6 access watchdog", cyc, 80);
        done = 1;
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    bus_ready = 1'b0;
    chk(req_ack == 1'b0, "R6 single ack pulse", req_ack, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "global watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(bus_strobe == 0 && bus_lock == 0 && req_ack == 0 && rd_done == 0,
        "R1 idle in reset", {bus_strobe, bus_lock, req_ack, rd_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_strobe == 0 && bus_lock == 0, "R1 idle after reset",
        {bus_strobe, bus_lock}, 0);
    access(1, 0, 24'h000100, 24'hABCDEF, 100, 0);   // R1: packing off by default
    access(0, 0, 24'h000200, 24'h0, 50, 0);         // R1, R8 read
    set_cfg(1);
    access(1, 0, 24'h001000, 24'h123456, 100, 0);   // R2, R3 back-to-back beats
    access(0, 0, 24'h002000, 24'h0, 100, 0);        // R4
    access(0, 0, 24'h003003, 24'h0, 25, 0);         // R5 slow ready
    access(1, 0, 24'h004004, 24'hF00D5A, 25, 0);    // R3, R5
    access(0, 0, 24'hFFFFFE, 24'h0, 60, 0);         // R2 wrap
    access(1, 1, 24'h005000, 24'h765432, 70, 0);    // R9 core write
    access(0, 1, 24'h005100, 24'h0, 70, 0);         // R9 core read
    access(0, 0, 24'h006000, 24'h0, 40, 1);         // R10 packed, cfg cleared mid-way
    access(1, 0, 24'h006100, 24'h112233, 40, 0);    // R10 now single
    access(0, 0, 24'h006200, 24'h0, 40, 1);         // R10 single, cfg set mid-way
    access(0, 0, 24'h006300, 24'h0, 40, 0);         // R10 now packed
    set_cfg(0);
    access(1, 0, 24'h007000, 24'hC0FFEE, 50, 0);    // R8
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra;
      logic [31:0] rd;
      logic [31:0] rm;
      ra = $urandom;
      rd = $urandom;
      rm = $urandom;
      if (rm[4:0] == 5'd0) set_cfg(rm[5]);
      access(rm[6], rm[9:7] == 3'd0, ra[23:0], rd[23:0],
             20 + int'(rm[15:10]), rm[20:16] == 5'd3);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule